// File: doc/BRIEF.md
# Debug Scan to Memory Bus Bridge

This block turns JTAG data-register scans into word accesses on a Wishbone classic bus. It sits behind a TAP controller. From the TAP it takes the current 4-bit instruction, the capture, shift and update strobes, TCK and TDI, and it drives TDO. Three instruction codes are decoded. The first loads a word address. The second streams words out of memory. The third streams words out while it stores the words that were shifted in.

Every memory scan is 32 bits long. The scan returns the word that sits at the current address. Under the read-write code, the shifted-in word is written back to that same address. After each memory scan the address moves on by one word, so a run of scans walks through consecutive words. A word is made ready for the next capture by a read that is issued ahead of time:

- Loading an address reads the word at that address.
- Each memory update reads the word at the following address.

The TCK and bus clock domains are asynchronous. Each request crosses from TCK to the bus clock as a two-flop toggle handshake, and each completion crosses back the same way. The request payload is held steady until its completion is seen.

Top module: `dbg_mem_bridge`

## Requirements
- R1: The instruction codes are 4'b0101 (address), 4'b0110 (read) and 4'b0111 (read-write). Under any other code, an update changes neither the address nor the bus, and the bus stays idle.
- R2: The address scan is 30 bits long, shifted least significant bit first (TDI in, TDO out). The capture presents the current address, and the update loads the shifted-in value as the new address.
- R3: Updating an address issues one bus read of the word at that address. That word is what the next memory-scan capture presents.
- R4: A read-code scan is 32 bits long, least significant bit first. It returns the word at the current address and issues no bus write.
- R5: A read-write scan returns the word stored at the current address before the scan. It then performs one bus write of the shifted-in word to that address, with all four byte selects set.
- R6: After each memory-scan update, the address advances by one word, wrapping modulo 2^30.
- R7: The bus is Wishbone classic. STB is never high without CYC. Address, data, WE and selects hold steady while STB waits for ACK. Read data is taken on the ACK edge.
- R8: After reset, the address is zero, CYC and STB are low, and TDO is low.
- R9: Each accepted update produces exactly one request in the bus domain. The number of bus cycles per request is as follows:
  - an address update: one read;
  - a read update: one read;
  - a read-write update: one write followed by one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tck_rst_n | input | 1 | Asynchronous active-low reset, TCK domain |
| jtag_ir | input | 4 | Current instruction from the TAP |
| cap_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| upd_dr | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, least significant bit first |
| sys_clk | input | 1 | Bus clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset, bus domain |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | 30 | Word address |
| wb_dat_o | output | 32 | Write data |
| wb_dat_i | input | 32 | Read data |
| wb_ack_i | input | 1 | Acknowledge |

## Verification
The assertions take three things for granted about the inputs:
- The TAP never raises a memory-scan capture while the previous request is still in flight.
- The TAP strobes are mutually exclusive.
- The bus slave raises ACK only during an active strobe.

The stimulus keeps within these limits in two ways:
- It drives exactly one strobe per TCK edge.
- It lets twenty idle TCK cycles pass after each update. That is far longer than two synchronizer hops plus a two-access bus exchange with up to two wait states.

// File: rtl/dbg_mem_pkg.sv
package dbg_mem_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_ADDR_CODE = 4'b0101;
  localparam logic [IR_W-1:0] IR_READ_CODE = 4'b0110;
  localparam logic [IR_W-1:0] IR_RDWR_CODE = 4'b0111;

  typedef enum logic [1:0] {
    WB_IDLE  = 2'd0,
    WB_WRITE = 2'd1,
    WB_READ  = 2'd2
  } wb_state_e;
endpackage

// File: rtl/dbg_toggle_sync.sv
module dbg_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = chain_q[STAGES] ^ chain_q[STAGES-1];
endmodule

// File: rtl/dbg_dr_tck.sv
module dbg_dr_tck
  import dbg_mem_pkg::*;
#(
  parameter int ADR_W       = 30,
  parameter int DAT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             tck,
  input  logic             tck_rst_n,
  input  logic [IR_W-1:0]  ir,
  input  logic             cap_dr,
  input  logic             shift_dr,
  input  logic             upd_dr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [DAT_W-1:0] rd_data_i,
  input  logic             done_tgl_i,
  output logic             req_tgl_o,
  output logic             req_we_o,
  output logic [ADR_W-1:0] req_wadr_o,
  output logic [DAT_W-1:0] req_wdat_o,
  output logic [ADR_W-1:0] req_radr_o
);
  localparam int PAD_W = DAT_W - ADR_W;

  logic             is_addr, is_mem, is_rdwr;
  logic [DAT_W-1:0] sr_q;
  logic [ADR_W-1:0] addr_q;
  logic             busy_q;
  logic             req_tgl_q;
  logic             done_pulse;

  assign is_addr = (ir == IR_ADDR_CODE);
  assign is_rdwr = (ir == IR_RDWR_CODE);
  assign is_mem  = (ir == IR_READ_CODE) || is_rdwr;

  dbg_toggle_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
    .clk    (tck),
    .rst_n  (tck_rst_n),
    .tgl_i  (done_tgl_i),
    .pulse_o(done_pulse)
  );

  // capture / shift path
  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      sr_q <= '0;
    end else if (cap_dr) begin
      if (is_addr)     sr_q <= {{PAD_W{1'b0}}, addr_q};
      else if (is_mem) sr_q <= rd_data_i;
    end else if (shift_dr) begin
      if (is_addr)     sr_q <= {{PAD_W{1'b0}}, tdi, sr_q[ADR_W-1:1]};
      else if (is_mem) sr_q <= {tdi, sr_q[DAT_W-1:1]};
    end
  end

  assign tdo = sr_q[0];

  // update path: address bookkeeping and request launch
  always_ff @(posedge tck or negedge tck_rst_n) begin
    if (!tck_rst_n) begin
      addr_q     <= '0;
      busy_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      req_we_o   <= 1'b0;
      req_wadr_o <= '0;
      req_wdat_o <= '0;
      req_radr_o <= '0;
    end else begin
      if (done_pulse) busy_q <= 1'b0;
      if (upd_dr && !busy_q) begin
        if (is_addr) begin
          addr_q     <= sr_q[ADR_W-1:0];
          req_we_o   <= 1'b0;
          req_radr_o <= sr_q[ADR_W-1:0];
          req_tgl_q  <= ~req_tgl_q;
          busy_q     <= 1'b1;
        end else if (is_mem) begin
          addr_q     <= addr_q + 1'b1;
          req_we_o   <= is_rdwr;
          req_wadr_o <= addr_q;
          req_wdat_o <= sr_q;
          req_radr_o <= addr_q + 1'b1;
          req_tgl_q  <= ~req_tgl_q;
          busy_q     <= 1'b1;
        end
      end
    end
  end

  assign req_tgl_o = req_tgl_q;

  assert_addr_step_R6: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (upd_dr && is_mem && !busy_q) |=> (addr_q == $past(addr_q) + 1'b1));

  assert_addr_load_R2: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (upd_dr && is_addr && !busy_q) |=> (addr_q == $past(sr_q[ADR_W-1:0])));

  assert_other_ir_inert_R1: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (upd_dr && !is_addr && !is_mem) |=> ($stable(addr_q) && $stable(req_tgl_q)));

  assert_capture_idle_R9: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (cap_dr && is_mem) |-> !busy_q);

  assert_one_request_R9: assert property (@(posedge tck) disable iff (!tck_rst_n)
    (upd_dr && (is_addr || is_mem) && !busy_q) |=> (req_tgl_q != $past(req_tgl_q)));
endmodule

// File: rtl/dbg_wb_master.sv
module dbg_wb_master
  import dbg_mem_pkg::*;
#(
  parameter int ADR_W       = 30,
  parameter int DAT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  input  logic               req_tgl_i,
  input  logic               req_we_i,
  input  logic [ADR_W-1:0]   req_wadr_i,
  input  logic [DAT_W-1:0]   req_wdat_i,
  input  logic [ADR_W-1:0]   req_radr_i,
  output logic               done_tgl_o,
  output logic [DAT_W-1:0]   rd_data_o,
  output logic               wb_cyc_o,
  output logic               wb_stb_o,
  output logic               wb_we_o,
  output logic [DAT_W/8-1:0] wb_sel_o,
  output logic [ADR_W-1:0]   wb_adr_o,
  output logic [DAT_W-1:0]   wb_dat_o,
  input  logic [DAT_W-1:0]   wb_dat_i,
  input  logic               wb_ack_i
);
  localparam int SEL_W = DAT_W / 8;

  wb_state_e st_q;
  logic      req_pulse;
  logic      done_q;

  dbg_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk    (sys_clk),
    .rst_n  (sys_rst_n),
    .tgl_i  (req_tgl_i),
    .pulse_o(req_pulse)
  );

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      st_q      <= WB_IDLE;
      wb_cyc_o  <= 1'b0;
      wb_stb_o  <= 1'b0;
      wb_we_o   <= 1'b0;
      wb_sel_o  <= '0;
      wb_adr_o  <= '0;
      wb_dat_o  <= '0;
      rd_data_o <= '0;
      done_q    <= 1'b0;
    end else begin
      unique case (st_q)
        WB_IDLE: if (req_pulse) begin
          wb_cyc_o <= 1'b1;
          wb_stb_o <= 1'b1;
          wb_sel_o <= {SEL_W{1'b1}};
          if (req_we_i) begin
            st_q     <= WB_WRITE;
            wb_we_o  <= 1'b1;
            wb_adr_o <= req_wadr_i;
            wb_dat_o <= req_wdat_i;
          end else begin
            st_q     <= WB_READ;
            wb_we_o  <= 1'b0;
            wb_adr_o <= req_radr_i;
          end
        end
        WB_WRITE: if (wb_ack_i) begin
          st_q     <= WB_READ;
          wb_we_o  <= 1'b0;
          wb_adr_o <= req_radr_i;
        end
        WB_READ: if (wb_ack_i) begin
          st_q      <= WB_IDLE;
          rd_data_o <= wb_dat_i;
          wb_cyc_o  <= 1'b0;
          wb_stb_o  <= 1'b0;
          wb_sel_o  <= '0;
          done_q    <= ~done_q;
        end
        default: st_q <= WB_IDLE;
      endcase
    end
  end

  assign done_tgl_o = done_q;

  assert_stb_in_cyc_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    wb_stb_o |-> wb_cyc_o);

  assert_hold_until_ack_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wb_stb_o && !wb_ack_i) |=> (wb_stb_o && $stable(wb_adr_o) && $stable(wb_we_o)
                                 && $stable(wb_dat_o) && $stable(wb_sel_o)));

  assert_write_full_word_R5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wb_stb_o && wb_we_o) |-> (wb_sel_o == {SEL_W{1'b1}}));

  assert_read_latch_R7: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wb_stb_o && !wb_we_o && wb_ack_i) |=> (rd_data_o == $past(wb_dat_i)));

  assert_write_then_read_R9: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (wb_stb_o && wb_we_o && wb_ack_i) |=> (wb_stb_o && !wb_we_o));
endmodule

// File: rtl/dbg_mem_bridge.sv
module dbg_mem_bridge
  import dbg_mem_pkg::*;
#(
  parameter int ADR_W       = 30,
  parameter int DAT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               tck,
  input  logic               tck_rst_n,
  input  logic [3:0]         jtag_ir,
  input  logic               cap_dr,
  input  logic               shift_dr,
  input  logic               upd_dr,
  input  logic               tdi,
  output logic               tdo,
  input  logic               sys_clk,
  input  logic               sys_rst_n,
  output logic               wb_cyc_o,
  output logic               wb_stb_o,
  output logic               wb_we_o,
  output logic [DAT_W/8-1:0] wb_sel_o,
  output logic [ADR_W-1:0]   wb_adr_o,
  output logic [DAT_W-1:0]   wb_dat_o,
  input  logic [DAT_W-1:0]   wb_dat_i,
  input  logic               wb_ack_i
);
  logic             req_tgl, req_we, done_tgl;
  logic [ADR_W-1:0] req_wadr, req_radr;
  logic [DAT_W-1:0] req_wdat, rd_data;

  dbg_dr_tck #(.ADR_W(ADR_W), .DAT_W(DAT_W), .SYNC_STAGES(SYNC_STAGES)) u_dr (
    .tck       (tck),
    .tck_rst_n (tck_rst_n),
    .ir        (jtag_ir),
    .cap_dr    (cap_dr),
    .shift_dr  (shift_dr),
    .upd_dr    (upd_dr),
    .tdi       (tdi),
    .tdo       (tdo),
    .rd_data_i (rd_data),
    .done_tgl_i(done_tgl),
    .req_tgl_o (req_tgl),
    .req_we_o  (req_we),
    .req_wadr_o(req_wadr),
    .req_wdat_o(req_wdat),
    .req_radr_o(req_radr)
  );

  dbg_wb_master #(.ADR_W(ADR_W), .DAT_W(DAT_W), .SYNC_STAGES(SYNC_STAGES)) u_wb (
    .sys_clk   (sys_clk),
    .sys_rst_n (sys_rst_n),
    .req_tgl_i (req_tgl),
    .req_we_i  (req_we),
    .req_wadr_i(req_wadr),
    .req_wdat_i(req_wdat),
    .req_radr_i(req_radr),
    .done_tgl_o(done_tgl),
    .rd_data_o (rd_data),
    .wb_cyc_o  (wb_cyc_o),
    .wb_stb_o  (wb_stb_o),
    .wb_we_o   (wb_we_o),
    .wb_sel_o  (wb_sel_o),
    .wb_adr_o  (wb_adr_o),
    .wb_dat_o  (wb_dat_o),
    .wb_dat_i  (wb_dat_i),
    .wb_ack_i  (wb_ack_i)
  );
endmodule

// File: tb/dbg_mem_bridge_bench.sv
module dbg_mem_bridge_bench;
  logic        sys_clk = 1'b0;
  logic        sys_rst_n = 1'b0;
  logic        tck = 1'b0;
  logic        tck_rst_n = 1'b0;
  logic [3:0]  jtag_ir = 4'h0;
  logic        cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0, tdi = 1'b0;
  logic        tdo;
  logic        wb_cyc_o, wb_stb_o, wb_we_o;
  logic [3:0]  wb_sel_o;
  logic [29:0] wb_adr_o;
  logic [31:0] wb_dat_o;
  logic [31:0] wb_dat_i = '0;
  logic        wb_ack_i = 1'b0;

  always #4 sys_clk = ~sys_clk;

  dbg_mem_bridge u_dbg_mem_bridge (
    .tck(tck), .tck_rst_n(tck_rst_n), .jtag_ir(jtag_ir), .cap_dr(cap_dr),
    .shift_dr(shift_dr), .upd_dr(upd_dr), .tdi(tdi), .tdo(tdo),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wb_cyc_o(wb_cyc_o),
    .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o), .wb_sel_o(wb_sel_o),
    .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack_i)
  );

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0;
  bit finished = 0;
  logic [31:0] mem [64];
  logic [31:0] ref_mem [64];
  logic [29:0] ref_adr = '0;
  logic [31:0] exp_q[$];
  logic [31:0] act_q[$];
  string       tag_q[$];
  logic [61:0] wexp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus slave with varying wait states; checks writes against the scoreboard
  initial begin
    int wcnt = 0;
    int seed = 0;
    forever begin
      @(posedge sys_clk);
      #1;
      if (wb_ack_i) wb_ack_i = 1'b0;
      else if (wb_cyc_o && wb_stb_o) begin
        if (wcnt > 0) wcnt--;
        else begin
          wb_ack_i = 1'b1;
          if (wb_we_o) begin
            logic [61:0] e;
            wr_cnt++;
            e = (wexp_q.size() > 0) ? wexp_q.pop_front() : '1;
            chk({wb_adr_o, wb_dat_o} == e, "R5 write addr/data", {2'b0, wb_adr_o, wb_dat_o}, {2'b0, e});
            chk(wb_sel_o == 4'hF, "R5 byte selects", 64'(wb_sel_o), 64'hF);
            mem[wb_adr_o[5:0]] = wb_dat_o;
          end else begin
            rd_cnt++;
            wb_dat_i = mem[wb_adr_o[5:0]];
          end
          seed++;
          wcnt = seed % 3;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge sys_clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [31:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a == e, t, 64'(a), 64'(e));
      end
    end
  end

  task automatic tck_cycle();
    #20 tck = 1'b1;
    #20 tck = 1'b0;
  endtask

  task automatic scan(input logic [3:0] code, input int n, input logic [31:0] din,
                      output logic [31:0] dout);
    dout = '0;
    jtag_ir = code;
    cap_dr = 1'b1; tck_cycle(); cap_dr = 1'b0;
    shift_dr = 1'b1;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #20;
      dout[i] = tdo;
      tck = 1'b1;
      #20;
      tck = 1'b0;
    end
    shift_dr = 1'b0;
    upd_dr = 1'b1; tck_cycle(); upd_dr = 1'b0;
    repeat (20) tck_cycle();
  endtask

  task automatic addr_scan(input logic [29:0] a, input string req);
    logic [31:0] d;
    int rd0;
    rd0 = rd_cnt;
    exp_q.push_back({2'b0, ref_adr});
    tag_q.push_back({req, " address capture"});
    scan(4'b0101, 30, {2'b0, a}, d);
    act_q.push_back(d);
    ref_adr = a;
    chk(rd_cnt == rd0 + 1, "R3 one read after address load", 64'(rd_cnt - rd0), 64'd1);
  endtask

  task automatic mem_scan(input bit rw, input logic [31:0] din, input string req);
    logic [31:0] d;
    int rd0, wr0;
    rd0 = rd_cnt; wr0 = wr_cnt;
    exp_q.push_back(ref_mem[ref_adr[5:0]]);
    tag_q.push_back(req);
    if (rw) begin
      wexp_q.push_back({ref_adr, din});
      ref_mem[ref_adr[5:0]] = din;
    end
    scan(rw ? 4'b0111 : 4'b0110, 32, din, d);
    act_q.push_back(d);
    ref_adr = ref_adr + 1'b1;
    chk(rd_cnt == rd0 + 1, "R9 one read per memory scan", 64'(rd_cnt - rd0), 64'd1);
    chk(wr_cnt == wr0 + (rw ? 1 : 0), rw ? "R5 one write" : "R4 no write",
        64'(wr_cnt - wr0), rw ? 64'd1 : 64'd0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] junk;
    int bus0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = {8'hC3, 8'(i), 16'(i * 37 + 5)};
      ref_mem[i] = mem[i];
    end
    repeat (3) tck_cycle();
    #3;
    tck_rst_n = 1'b1;
    sys_rst_n = 1'b1;
    @(negedge sys_clk);
    chk(!wb_cyc_o && !wb_stb_o, "R8 bus idle after reset", {62'b0, wb_cyc_o, wb_stb_o}, 64'd0);
    chk(tdo == 1'b0, "R8 tdo low after reset", 64'(tdo), 64'd0);

    addr_scan(30'd5, "R8 R2 reset address");
    mem_scan(1'b0, 32'h0, "R4 R3 read at 5");
    mem_scan(1'b0, 32'hFFFF_FFFF, "R4 R6 read at 6");
    addr_scan(30'd10, "R6 R2 address after two reads");
    mem_scan(1'b1, 32'h5555_5555, "R5 read-write at 10");
    mem_scan(1'b1, 32'hAAAA_AAAA, "R5 read-write at 11");
    addr_scan(30'd10, "R6 R2 address after two writes");
    mem_scan(1'b0, 32'h0, "R5 R4 readback at 10");
    mem_scan(1'b0, 32'h0, "R5 R4 readback at 11");

    bus0 = rd_cnt + wr_cnt;
    scan(4'b0000, 32, 32'hDEAD_BEEF, junk);
    chk(rd_cnt + wr_cnt == bus0, "R1 no bus cycle for unknown code", 64'(rd_cnt + wr_cnt - bus0), 64'd0);
    addr_scan(30'h3FFF_FFFF, "R1 address unchanged by unknown code");
    mem_scan(1'b0, 32'h0, "R4 read at top address");
    addr_scan(30'd0, "R6 address wraps to zero");
    mem_scan(1'b1, 32'h1234_5678, "R5 read-write at 0");
    mem_scan(1'b0, 32'h0, "R4 read at 1");

    repeat (10) @(negedge sys_clk);
    chk(wexp_q.size() == 0, "R5 all expected writes seen", 64'(wexp_q.size()), 64'd0);
    chk(exp_q.size() == 0, "R9 all scans compared", 64'(exp_q.size()), 64'd0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule